// File: doc/BRIEF.md
# Frame Buffer Fetch Sequencer with Palette Preload

This block issues burst read requests to memory on behalf of a display engine. It can load a colour lookup table (the palette) first and then fetch picture data. The picture data comes either from one memory region, over and over, or from two regions in turn. Each region is described by a start address and a last-byte address, and the last-byte address is inclusive. The block works in byte addresses and fetches whole 4-byte words. It steps through each region in bursts whose size comes from a small code. It shortens the final burst of a region so that it never reads past the region's last byte.

Every request carries an address and a word count and stays up until the memory side acknowledges it. The memory side then returns exactly that many data beats, which the sequencer counts. A one-cycle event marks the end of the palette and the end of each region. A global enable gates all activity. When the enable is cleared the sequencer finishes the burst it has already had accepted and then goes quiet. When the enable is set again, fetching restarts from the beginning of the selected mode.

Top module: `fb_fetch_seq`

## Requirements
- R1: After reset no request is pending and all three event outputs are low.
- R2: While `en_i` is low, no new request is raised.
- R3: `burst_code_i` gives the burst length in words: 0→1, 1→2, 2→4, 3→8, 4→16. Codes 5, 6 and 7 are invalid, and with an invalid code no fetch starts.
- R4: `load_mode_i` selects the sequence. 0 loads the palette and then picture data. 1 loads the palette only and then makes no further request until the enable is cleared. 2 loads picture data only. 3 fetches nothing.
- R5: The palette region starts at `pal_base_i` and is 32 bytes (8 words) long, or 512 bytes (128 words) when `pal_wide_i` is 1.
- R6: A region's first request is at its start address. Each later request is at the previous address plus 4 times the previous length. An unacknowledged request holds its address.
- R7: Each request is the burst length or the number of words left before the inclusive last-byte address, whichever is smaller.
- R8: With `dual_i` at 1, picture regions alternate buffer 0, buffer 1, buffer 0, and so on. With `dual_i` at 0, only buffer 0 is fetched.
- R9: `pal_done_o`, `frame0_done_o` and `frame1_done_o` each pulse for one cycle, in the cycle after the last data beat of the palette, of buffer 0 or of buffer 1. At most one of them is high at a time.
- R10: A start or last-byte address changed while a region is being fetched takes effect at that buffer's next region start.
- R11: Clearing `en_i` withdraws a request that has not been acknowledged. A burst that has been accepted still receives all its beats. Then the sequencer idles, and setting `en_i` again restarts the selected mode from its first region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global fetch enable |
| load_mode_i | input | 2 | Sequence select (R4 encoding) |
| dual_i | input | 1 | Alternate between two picture buffers |
| burst_code_i | input | 3 | Burst length code (R3 encoding) |
| pal_wide_i | input | 1 | Selects the 512-byte palette |
| pal_base_i | input | AW | Palette start byte address |
| buf0_base_i | input | AW | Buffer 0 start byte address |
| buf0_ceil_i | input | AW | Buffer 0 inclusive last byte address |
| buf1_base_i | input | AW | Buffer 1 start byte address |
| buf1_ceil_i | input | AW | Buffer 1 inclusive last byte address |
| req_valid_o | output | 1 | Burst request pending |
| req_addr_o | output | AW | Burst start byte address |
| req_len_o | output | MAX_BURST_LG+1 | Burst length in words |
| req_ack_i | input | 1 | Request accepted this cycle |
| rd_valid_i | input | 1 | One returned data word this cycle |
| pal_done_o | output | 1 | Palette fetch complete pulse |
| frame0_done_o | output | 1 | Buffer 0 fetch complete pulse |
| frame1_done_o | output | 1 | Buffer 1 fetch complete pulse |

## Verification
A behavioural model runs alongside the design and is compared with it every cycle. Stimulus includes a 10-word region fetched in 4-word bursts, which tells exact stepping apart from an overrun at the last-byte address. It also includes 16-word bursts over a 10-word region, which shows that a region smaller than one burst is clipped. The acknowledge and data-beat responses are run both back to back and with gaps, so that the holding of a request and the beat counting are seen under stalls. The two-buffer run tells alternation apart from repeated fetches of buffer 0. Palette-only, palette-then-data, invalid-code and mode-3 runs each separate a correct phase order from a missed or extra phase. Moving a base address in the middle of a region, and dropping the enable during an accepted burst, show whether new settings are picked up only at a region start and whether the sequence restarts from the beginning.

// File: rtl/fb_fetch_pkg.sv
package fb_fetch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_DATA,
        ST_HOLD
    } fetch_st_e;

    typedef enum logic [1:0] {
        PH_PAL,
        PH_BUF0,
        PH_BUF1
    } fetch_ph_e;

    localparam logic [1:0] LM_PAL_DATA  = 2'd0;
    localparam logic [1:0] LM_PAL_ONLY  = 2'd1;
    localparam logic [1:0] LM_DATA_ONLY = 2'd2;
    localparam logic [1:0] LM_NONE      = 2'd3;

endpackage

// File: rtl/fb_fetch_burst.sv
// Burst length for the current position: the coded burst size, clipped
// to the number of words left up to the inclusive last byte.
module fb_fetch_burst #(
    parameter int AW           = 32,
    parameter int WB_LG        = 2,
    parameter int MAX_BURST_LG = 4,
    parameter int LEN_W        = MAX_BURST_LG + 1
) (
    input  logic [2:0]       code_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [AW-1:0]    ceil_i,
    output logic [LEN_W-1:0] len_o,
    output logic             code_ok_o
);
    logic [AW-1:0]    words_left;
    logic [LEN_W-1:0] burst_words;

    always_comb begin
        code_ok_o   = 32'(code_i) <= 32'(MAX_BURST_LG);
        burst_words = code_ok_o ? (LEN_W'(1) << code_i) : LEN_W'(1);
        words_left  = ((ceil_i - addr_i) >> WB_LG) + AW'(1);
        if (words_left < AW'(burst_words)) begin
            len_o = words_left[LEN_W-1:0];
        end else begin
            len_o = burst_words;
        end
    end
endmodule

// File: rtl/fb_fetch_region.sv
// Start and inclusive last-byte address of the region a phase fetches.
module fb_fetch_region
    import fb_fetch_pkg::*;
#(
    parameter int AW              = 32,
    parameter int PAL_SMALL_BYTES = 32,
    parameter int PAL_LARGE_BYTES = 512
) (
    input  fetch_ph_e     ph_i,
    input  logic          pal_wide_i,
    input  logic [AW-1:0] pal_base_i,
    input  logic [AW-1:0] buf0_base_i,
    input  logic [AW-1:0] buf0_ceil_i,
    input  logic [AW-1:0] buf1_base_i,
    input  logic [AW-1:0] buf1_ceil_i,
    output logic [AW-1:0] base_o,
    output logic [AW-1:0] ceil_o
);
    localparam logic [AW-1:0] PAL_SMALL_SPAN = AW'(PAL_SMALL_BYTES - 1);
    localparam logic [AW-1:0] PAL_LARGE_SPAN = AW'(PAL_LARGE_BYTES - 1);

    always_comb begin
        unique case (ph_i)
            PH_PAL: begin
                base_o = pal_base_i;
                ceil_o = pal_base_i + (pal_wide_i ? PAL_LARGE_SPAN : PAL_SMALL_SPAN);
            end
            PH_BUF1: begin
                base_o = buf1_base_i;
                ceil_o = buf1_ceil_i;
            end
            default: begin
                base_o = buf0_base_i;
                ceil_o = buf0_ceil_i;
            end
        endcase
    end
endmodule

// File: rtl/fb_fetch_seq.sv
// Burst fetch sequencer: palette phase, then one or two picture regions.
module fb_fetch_seq
    import fb_fetch_pkg::*;
#(
    parameter int AW              = 32,
    parameter int WORD_BYTES      = 4,
    parameter int MAX_BURST_LG    = 4,
    parameter int PAL_SMALL_BYTES = 32,
    parameter int PAL_LARGE_BYTES = 512
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_i,
    input  logic [1:0]            load_mode_i,
    input  logic                  dual_i,
    input  logic [2:0]            burst_code_i,
    input  logic                  pal_wide_i,
    input  logic [AW-1:0]         pal_base_i,
    input  logic [AW-1:0]         buf0_base_i,
    input  logic [AW-1:0]         buf0_ceil_i,
    input  logic [AW-1:0]         buf1_base_i,
    input  logic [AW-1:0]         buf1_ceil_i,
    output logic                  req_valid_o,
    output logic [AW-1:0]         req_addr_o,
    output logic [MAX_BURST_LG:0] req_len_o,
    input  logic                  req_ack_i,
    input  logic                  rd_valid_i,
    output logic                  pal_done_o,
    output logic                  frame0_done_o,
    output logic                  frame1_done_o
);
    localparam int WB_LG = $clog2(WORD_BYTES);
    localparam int LEN_W = MAX_BURST_LG + 1;

    typedef struct packed {
        fetch_st_e        st;
        fetch_ph_e        ph;
        logic [1:0]       mode;
        logic [AW-1:0]    addr;
        logic [AW-1:0]    ceil;
        logic [LEN_W-1:0] beats;
        logic             pal_done;
        logic             eof0;
        logic             eof1;
    } seq_t;

    seq_t             seq_d, seq_q;
    fetch_ph_e        launch_ph;
    logic [AW-1:0]    sel_base, sel_ceil;
    logic [LEN_W-1:0] burst_len;
    logic             code_ok;
    logic [AW-1:0]    step_bytes;
    logic             region_end;
    logic [AW-1:0]    region_ceil;

    fb_fetch_burst #(
        .AW(AW), .WB_LG(WB_LG), .MAX_BURST_LG(MAX_BURST_LG), .LEN_W(LEN_W)
    ) u_burst (
        .code_i   (burst_code_i),
        .addr_i   (seq_q.addr),
        .ceil_i   (seq_q.ceil),
        .len_o    (burst_len),
        .code_ok_o(code_ok)
    );

    fb_fetch_region #(
        .AW(AW), .PAL_SMALL_BYTES(PAL_SMALL_BYTES), .PAL_LARGE_BYTES(PAL_LARGE_BYTES)
    ) u_region (
        .ph_i       (launch_ph),
        .pal_wide_i (pal_wide_i),
        .pal_base_i (pal_base_i),
        .buf0_base_i(buf0_base_i),
        .buf0_ceil_i(buf0_ceil_i),
        .buf1_base_i(buf1_base_i),
        .buf1_ceil_i(buf1_ceil_i),
        .base_o     (sel_base),
        .ceil_o     (sel_ceil)
    );

    // Phase the next region start will use.
    always_comb begin
        if (seq_q.st == ST_IDLE) begin
            launch_ph = (load_mode_i == LM_DATA_ONLY) ? PH_BUF0 : PH_PAL;
        end else if (seq_q.ph == PH_BUF0 && dual_i) begin
            launch_ph = PH_BUF1;
        end else begin
            launch_ph = PH_BUF0;
        end
    end

    assign step_bytes  = AW'(burst_len) << WB_LG;
    assign region_end  = seq_q.addr > seq_q.ceil;
    assign region_ceil = seq_q.ceil;

    always_comb begin
        seq_d          = seq_q;
        seq_d.pal_done = 1'b0;
        seq_d.eof0     = 1'b0;
        seq_d.eof1     = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (en_i && code_ok && load_mode_i != LM_NONE) begin
                    seq_d.mode = load_mode_i;
                    seq_d.ph   = launch_ph;
                    seq_d.addr = sel_base;
                    seq_d.ceil = sel_ceil;
                    seq_d.st   = ST_REQ;
                end
            end
            ST_REQ: begin
                if (req_ack_i) begin
                    seq_d.beats = burst_len;
                    seq_d.addr  = seq_q.addr + step_bytes;
                    seq_d.st    = ST_DATA;
                end else if (!en_i || !code_ok) begin
                    seq_d.st = ST_IDLE;
                end
            end
            ST_DATA: begin
                if (rd_valid_i) begin
                    seq_d.beats = seq_q.beats - LEN_W'(1);
                    if (seq_q.beats == LEN_W'(1)) begin
                        if (region_end) begin
                            seq_d.pal_done = (seq_q.ph == PH_PAL);
                            seq_d.eof0     = (seq_q.ph == PH_BUF0);
                            seq_d.eof1     = (seq_q.ph == PH_BUF1);
                            if (!en_i) begin
                                seq_d.st = ST_IDLE;
                            end else if (seq_q.ph == PH_PAL && seq_q.mode == LM_PAL_ONLY) begin
                                seq_d.st = ST_HOLD;
                            end else begin
                                seq_d.ph   = launch_ph;
                                seq_d.addr = sel_base;
                                seq_d.ceil = sel_ceil;
                                seq_d.st   = ST_REQ;
                            end
                        end else begin
                            seq_d.st = en_i ? ST_REQ : ST_IDLE;
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (!en_i) seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_valid_o   = (seq_q.st == ST_REQ);
    assign req_addr_o    = seq_q.addr;
    assign req_len_o     = burst_len;
    assign pal_done_o    = seq_q.pal_done;
    assign frame0_done_o = seq_q.eof0;
    assign frame1_done_o = seq_q.eof1;
endmodule

// File: rtl/fb_fetch_chk.sv
module fb_fetch_chk #(
    parameter int AW           = 32,
    parameter int WB_LG        = 2,
    parameter int MAX_BURST_LG = 4,
    parameter int LEN_W        = MAX_BURST_LG + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic [2:0]       burst_code_i,
    input logic             req_ack_i,
    input logic             req_valid_o,
    input logic [AW-1:0]    req_addr_o,
    input logic [LEN_W-1:0] req_len_o,
    input logic [AW-1:0]    region_ceil,
    input logic             pal_done_o,
    input logic             frame0_done_o,
    input logic             frame1_done_o
);
    logic code_legal;
    assign code_legal = 32'(burst_code_i) <= 32'(MAX_BURST_LG);

    assert_len_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_len_o != '0) && (32'(req_len_o) <= (32'd1 << burst_code_i)));

    assert_below_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> ((AW+1)'(req_addr_o) + ((AW+1)'(req_len_o) << WB_LG) - (AW+1)'(1))
                        <= (AW+1)'(region_ceil));

    assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ack_i && en_i && code_legal) |=> (req_valid_o && $stable(req_addr_o)));

    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !req_valid_o) |=> !req_valid_o);

    assert_one_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pal_done_o, frame0_done_o, frame1_done_o}));

    assert_pal_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pal_done_o |=> !pal_done_o);

    assert_eof0_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame0_done_o |=> !frame0_done_o);

    assert_eof1_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame1_done_o |=> !frame1_done_o);
endmodule

bind fb_fetch_seq fb_fetch_chk #(
    .AW(AW), .WB_LG(WB_LG), .MAX_BURST_LG(MAX_BURST_LG), .LEN_W(LEN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .burst_code_i (burst_code_i),
    .req_ack_i    (req_ack_i),
    .req_valid_o  (req_valid_o),
    .req_addr_o   (req_addr_o),
    .req_len_o    (req_len_o),
    .region_ceil  (region_ceil),
    .pal_done_o   (pal_done_o),
    .frame0_done_o(frame0_done_o),
    .frame1_done_o(frame1_done_o)
);

// File: tb/fb_fetch_seq_tb.sv
module fb_fetch_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        en = 1'b0;
    logic [1:0]  lmode = 2'd0;
    logic        dual = 1'b0;
    logic [2:0]  bcode = 3'd0;
    logic        palw = 1'b0;
    logic [31:0] pal_base = '0, b0b = '0, b0c = '0, b1b = '0, b1c = '0;
    logic        ack = 1'b0, rdv = 1'b0;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [4:0]  req_len;
    logic        pdone, f0, f1;

    fb_fetch_seq u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .load_mode_i(lmode), .dual_i(dual),
        .burst_code_i(bcode), .pal_wide_i(palw), .pal_base_i(pal_base),
        .buf0_base_i(b0b), .buf0_ceil_i(b0c), .buf1_base_i(b1b), .buf1_ceil_i(b1c),
        .req_valid_o(req_valid), .req_addr_o(req_addr), .req_len_o(req_len),
        .req_ack_i(ack), .rd_valid_i(rdv),
        .pal_done_o(pdone), .frame0_done_o(f0), .frame1_done_o(f1)
    );

    int     n_chk = 0, n_bad = 0, cyc = 0, pend = 0;
    string  cur_req = "R1";
    bit     ack_all = 1'b1, rdv_all = 1'b1;
    longint hs_a[$];
    int     hs_l[$];
    int     ev_q[$];

    // behavioural reference: st 0 idle, 1 request, 2 data, 3 hold; ph 0 palette, 1 buf0, 2 buf1
    int     m_st = 0, m_ph = 0, m_mode = 0, m_beats = 0;
    longint m_addr = 0, m_ceil = 0;
    bit     m_p = 0, m_e0 = 0, m_e1 = 0, m_ok = 0;

    function automatic int m_len();
        longint wl = (m_ceil - m_addr) / 4 + 1;
        int bw = (bcode <= 3'd4) ? (1 << bcode) : 1;
        return (wl < bw) ? int'(wl) : bw;
    endfunction

    task automatic m_load();
        case (m_ph)
            0: begin m_addr = pal_base; m_ceil = longint'(pal_base) + (palw ? 512 : 32) - 1; end
            1: begin m_addr = b0b; m_ceil = b0c; end
            default: begin m_addr = b1b; m_ceil = b1c; end
        endcase
    endtask

    task automatic chk(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_ph = 0; m_mode = 0; m_beats = 0; m_addr = 0; m_ceil = 0;
            m_p = 0; m_e0 = 0; m_e1 = 0; pend = 0;
        end else begin
            if (req_valid && ack) begin
                hs_a.push_back(longint'(req_addr));
                hs_l.push_back(int'(req_len));
                pend += int'(req_len);
            end
            if (rdv) pend--;
            m_ok = (bcode <= 3'd4);
            m_p = 0; m_e0 = 0; m_e1 = 0;
            case (m_st)
                0: if (en && m_ok && lmode != 2'd3) begin
                    m_mode = lmode; m_ph = (lmode == 2'd2) ? 1 : 0; m_load(); m_st = 1;
                end
                1: if (ack) begin
                    m_beats = m_len(); m_addr += 4 * m_beats; m_st = 2;
                end else if (!en || !m_ok) m_st = 0;
                2: if (rdv) begin
                    m_beats--;
                    if (m_beats == 0) begin
                        if (m_addr > m_ceil) begin
                            if (m_ph == 0) m_p = 1; else if (m_ph == 1) m_e0 = 1; else m_e1 = 1;
                            if (!en) m_st = 0;
                            else if (m_ph == 0 && m_mode == 1) m_st = 3;
                            else begin m_ph = (m_ph == 1 && dual) ? 2 : 1; m_load(); m_st = 1; end
                        end else m_st = en ? 1 : 0;
                    end
                end
                default: if (!en) m_st = 0;
            endcase
        end
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL %s watchdog expired actual=%0d expected=%0d", cur_req, cyc, 100000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // per-cycle comparison against the reference, and event log
    always @(negedge clk) begin
        chk(cur_req, "req_valid", longint'(req_valid), longint'(m_st == 1));
        if (m_st == 1) begin
            chk(cur_req, "req_addr", longint'(req_addr), m_addr);
            chk(cur_req, "req_len", longint'(req_len), longint'(m_len()));
        end
        chk(cur_req, "pal_done", longint'(pdone), longint'(m_p));
        chk(cur_req, "frame0_done", longint'(f0), longint'(m_e0));
        chk(cur_req, "frame1_done", longint'(f1), longint'(m_e1));
        if (pdone) ev_q.push_back(0);
        if (f0) ev_q.push_back(1);
        if (f1) ev_q.push_back(2);
    end

    // memory responder
    always @(negedge clk) begin
        #1;
        ack = req_valid && (ack_all || (cyc % 2 == 0));
        rdv = (pend > 0) && (rdv_all || (cyc % 3 != 0));
    end

    task automatic step(int n);
        repeat (n) begin @(negedge clk); #2; end
    endtask

    function automatic int count_ev(int kind);
        int c = 0;
        foreach (ev_q[i]) if (ev_q[i] == kind) c++;
        return c;
    endfunction

    task automatic wait_ev(int kind, int n);
        for (int i = 0; i < 5000; i++) begin
            if (count_ev(kind) >= n) return;
            step(1);
        end
        chk(cur_req, "event wait", longint'(count_ev(kind)), longint'(n));
    endtask

    task automatic wait_hs(int n);
        for (int i = 0; i < 5000; i++) begin
            if (hs_a.size() >= n) return;
            step(1);
        end
        chk(cur_req, "request wait", longint'(hs_a.size()), longint'(n));
    endtask

    task automatic quiesce();
        en = 1'b0;
        step(40);
        hs_a.delete(); hs_l.delete(); ev_q.delete();
    endtask

    initial begin
        step(3);
        chk("R1", "req_valid in reset", longint'(req_valid), 0);
        chk("R1", "events in reset", longint'({pdone, f0, f1}), 0);
        rst_n = 1'b1;
        step(2);

        // enable low: nothing fetched
        cur_req = "R2";
        lmode = 2'd2; bcode = 3'd2; b0b = 32'h1000; b0c = 32'h1027; dual = 1'b0;
        step(20);
        chk("R2", "requests while disabled", longint'(hs_a.size()), 0);

        // 10-word region in 4-word bursts
        cur_req = "R7";
        en = 1'b1;
        wait_ev(1, 3);
        chk("R6", "burst0 addr", hs_a[0], 64'h1000);
        chk("R6", "burst1 addr", hs_a[1], 64'h1010);
        chk("R6", "burst2 addr", hs_a[2], 64'h1020);
        chk("R3", "burst0 len", longint'(hs_l[0]), 4);
        chk("R7", "clipped len", longint'(hs_l[2]), 2);
        chk("R9", "event count", longint'(ev_q.size()), 3);
        chk("R9", "requests for 3 frames", longint'(hs_a.size()), 9);
        quiesce();

        // two alternating buffers with stalls
        cur_req = "R8";
        b1b = 32'h8000; b1c = 32'h803F; bcode = 3'd4; dual = 1'b1;
        ack_all = 1'b0; rdv_all = 1'b0;
        en = 1'b1;
        wait_ev(2, 2);
        chk("R8", "event order 0", longint'(ev_q[0]), 1);
        chk("R8", "event order 1", longint'(ev_q[1]), 2);
        chk("R8", "event order 2", longint'(ev_q[2]), 1);
        chk("R8", "event order 3", longint'(ev_q[3]), 2);
        chk("R8", "buf1 addr", hs_a[1], 64'h8000);
        chk("R8", "buf1 len", longint'(hs_l[1]), 16);
        chk("R7", "short region len", longint'(hs_l[0]), 10);
        quiesce();

        // palette then data
        cur_req = "R5";
        dual = 1'b0; lmode = 2'd0; pal_base = 32'h200; palw = 1'b0; bcode = 3'd4;
        en = 1'b1;
        wait_ev(1, 1);
        chk("R4", "palette event first", longint'(ev_q[0]), 0);
        chk("R4", "data event second", longint'(ev_q[1]), 1);
        chk("R5", "palette addr", hs_a[0], 64'h200);
        chk("R5", "small palette len", longint'(hs_l[0]), 8);
        chk("R4", "data after palette", hs_a[1], 64'h1000);
        quiesce();

        // palette only, large palette
        cur_req = "R4";
        lmode = 2'd1; palw = 1'b1; pal_base = 32'h400; bcode = 3'd3;
        ack_all = 1'b1; rdv_all = 1'b1;
        en = 1'b1;
        wait_ev(0, 1);
        step(50);
        chk("R5", "large palette bursts", longint'(hs_a.size()), 16);
        chk("R5", "last palette addr", hs_a[15], 64'h5E0);
        chk("R4", "hold after palette", longint'(req_valid), 0);
        chk("R4", "single palette event", longint'(ev_q.size()), 1);
        quiesce();

        // invalid code, then mode 3
        cur_req = "R3";
        lmode = 2'd2; bcode = 3'd5; palw = 1'b0;
        en = 1'b1;
        step(50);
        chk("R3", "invalid code requests", longint'(hs_a.size()), 0);
        quiesce();
        cur_req = "R4";
        bcode = 3'd2; lmode = 2'd3;
        en = 1'b1;
        step(50);
        chk("R4", "mode 3 requests", longint'(hs_a.size()), 0);
        quiesce();

        // single-word bursts
        cur_req = "R3";
        lmode = 2'd2; bcode = 3'd0; b0b = 32'h100; b0c = 32'h10B;
        en = 1'b1;
        wait_ev(1, 1);
        chk("R3", "code0 addr0", hs_a[0], 64'h100);
        chk("R3", "code0 addr2", hs_a[2], 64'h108);
        chk("R3", "code0 len", longint'(hs_l[1]), 1);
        quiesce();

        // base moved mid-region
        cur_req = "R10";
        bcode = 3'd1; b0b = 32'h1000; b0c = 32'h100F; rdv_all = 1'b0;
        en = 1'b1;
        wait_hs(1);
        b0b = 32'h3000; b0c = 32'h300F;
        wait_ev(1, 2);
        chk("R10", "old region continues", hs_a[1], 64'h1008);
        chk("R10", "new base next frame", hs_a[2], 64'h3000);
        chk("R10", "new region step", hs_a[3], 64'h3008);
        quiesce();

        // enable dropped during an accepted burst
        cur_req = "R11";
        bcode = 3'd4; b0b = 32'h4000; b0c = 32'h40FF;
        en = 1'b1;
        wait_hs(1);
        en = 1'b0;
        step(60);
        chk("R11", "no request after disable", longint'(hs_a.size()), 1);
        chk("R11", "burst beats all returned", longint'(pend), 0);
        chk("R11", "idle after disable", longint'(req_valid), 0);
        en = 1'b1;
        wait_hs(2);
        chk("R11", "restart at base", hs_a[1], 64'h4000);
        quiesce();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule